// File: doc/BRIEF.md
# Sequential Double-Width Integer Divider

This block divides a dividend of twice the data width, presented as an upper half and a lower half, by a single-width divisor. A one-cycle `start` pulse hands over the operands together with a mode bit that selects unsigned or two's-complement arithmetic. The block answers with a single-width quotient and a single-width remainder, or it reports a divide error. An error is reported when the divisor is zero or when the true quotient cannot be represented in the data width.

The general case runs a restoring shift-and-subtract loop with one quotient bit per clock. Two kinds of operation finish in the cycle after `start` without entering the loop. The first is an operation that is certain to overflow, because the upper half of the dividend magnitude is not below the divisor magnitude. The second, when the fast path is enabled, is an operation whose upper magnitude half is zero. Signed operands are reduced to magnitudes before division, and the signs are restored at the end. The signed range check is asymmetric: a negative quotient may reach the most negative value.

Top module: `wide_divider`

## Requirements
- R1: A divisor of zero gives `div_err` with `done`, and `quot`/`rem` keep their previous values.
- R2: When the upper N bits of the dividend magnitude are greater than or equal to the divisor magnitude (with a nonzero divisor), `div_err` is raised with `done` on the cycle after `start`, and `busy` never rises.
- R3: With FAST_PATH=1 and the upper N bits of the dividend magnitude equal to zero, the result (or a range error) appears with `done` on the cycle after `start`.
- R4: Every other accepted operation completes N+1 cycles after the `start` cycle. In unsigned mode (`sgn_mode`=0) it gives quot = floor({dvd_hi,dvd_lo}/divisor) and rem = {dvd_hi,dvd_lo} mod divisor.
- R5: In signed mode (`sgn_mode`=1), {dvd_hi,dvd_lo} is read as a 2N-bit two's-complement value and `divisor` as an N-bit one. The quotient is truncated toward zero, and the remainder carries the sign of the dividend.
- R6: In signed mode a quotient is out of range, and gives `div_err`, when its true value is above 2^(N-1)-1 or below -2^(N-1). A quotient of exactly -2^(N-1) is valid.
- R7: `busy` is high from the cycle after a loop-bound `start` until the result cycle, and it is low in the `done` cycle. A `start` seen while `busy` is high is ignored and produces no result.
- R8: `done` is high for one cycle per accepted operation, and exactly one of `res_ok` and `div_err` is high with it. Neither is high without `done`.
- R9: After reset, `busy`, `done`, `res_ok` and `div_err` are low and `quot`, `rem` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Operation request, sampled when not busy |
| sgn_mode | input | 1 | 1 = two's-complement division, 0 = unsigned |
| dvd_hi | input | N | Upper half of the dividend |
| dvd_lo | input | N | Lower half of the dividend |
| divisor | input | N | Divisor |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion pulse |
| res_ok | output | 1 | Result valid, with `done` |
| div_err | output | 1 | Divide error, with `done` |
| quot | output | N | Quotient register |
| rem | output | N | Remainder register |

## Verification
The assertions check on every cycle that a result cycle carries exactly one outcome and is never flagged busy. They also check that the registers hold their values across an error, that a zero divisor or a certain overflow errors on the next cycle without the loop being entered, that the loop counter steps down by one each cycle, and that the loop is never loaded while it is running. Only the bench's scenarios can show the numerical correctness of quotient and remainder against a reference built from the language's own divide and modulo operators. The same holds for the asymmetric signed boundary at -2^(N-1), the most-negative dividend and divisor, the exact latency of each path, and the silence after starts sent while busy. The bench covers all of these at both N=8 and N=16.

// File: rtl/wide_divider_pkg.sv
package wide_divider_pkg;
  typedef enum logic [1:0] {
    OUT_NONE = 2'b00,
    OUT_OK   = 2'b01,
    OUT_ERR  = 2'b10
  } div_outcome_e;
endpackage

// File: rtl/wide_divider_prep.sv
module wide_divider_prep #(
  parameter int N = 16
) (
  input  logic         sgn,
  input  logic [N-1:0] hi,
  input  logic [N-1:0] lo,
  input  logic [N-1:0] dvs,
  output logic [N-1:0] mag_hi,
  output logic [N-1:0] mag_lo,
  output logic [N-1:0] mag_d,
  output logic         neg_q,
  output logic         neg_r,
  output logic         zero_d,
  output logic         pre_ovf,
  output logic         hi_zero
);
  localparam int W2 = 2 * N;

  function automatic logic [W2-1:0] abs_wide(input logic neg, input logic [W2-1:0] v);
    return neg ? (~v + 1'b1) : v;
  endfunction

  function automatic logic [N-1:0] abs_narrow(input logic neg, input logic [N-1:0] v);
    return neg ? (~v + 1'b1) : v;
  endfunction

  logic          s_a, s_b;
  logic [W2-1:0] mag_full;

  always_comb begin
    s_a      = sgn & hi[N-1];
    s_b      = sgn & dvs[N-1];
    mag_full = abs_wide(s_a, {hi, lo});
    mag_hi   = mag_full[W2-1:N];
    mag_lo   = mag_full[N-1:0];
    mag_d    = abs_narrow(s_b, dvs);
    neg_q    = s_a ^ s_b;
    neg_r    = s_a;
    zero_d   = (dvs == '0);
    pre_ovf  = !zero_d && (mag_hi >= mag_d);
    hi_zero  = (mag_hi == '0);
  end
endmodule

// File: rtl/wide_divider_core.sv
module wide_divider_core #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] in_hi,
  input  logic [N-1:0] in_lo,
  input  logic [N-1:0] in_d,
  output logic         running,
  output logic         fin,
  output logic [N-1:0] q_mag,
  output logic [N-1:0] r_mag
);
  localparam int CW = $clog2(N + 1);
  localparam logic [CW-1:0] ITER = CW'(N);

  // one restoring step: capture top bit, shift pair, conditional subtract
  function automatic logic [2*N-1:0] rs_step(input logic [N-1:0] rh,
                                             input logic [N-1:0] rl,
                                             input logic [N-1:0] d);
    logic         top;
    logic         qb;
    logic [N-1:0] sh;
    logic [N-1:0] sl;
    top = rh[N-1];
    sh  = {rh[N-2:0], rl[N-1]};
    sl  = {rl[N-2:0], 1'b0};
    qb  = top || (sh >= d);
    if (qb) sh = sh - d;
    sl[0] = qb;
    return {sh, sl};
  endfunction

  logic [N-1:0]  rem_q, quo_q, dsr_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          stepping;
  logic [2*N-1:0] nxt;

  assign stepping = run_q && (cnt_q != '0);
  assign fin      = run_q && (cnt_q == '0);
  assign running  = run_q;
  assign q_mag    = quo_q;
  assign r_mag    = rem_q;
  assign nxt      = rs_step(rem_q, quo_q, dsr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      rem_q <= in_hi;
      quo_q <= in_lo;
      dsr_q <= in_d;
      cnt_q <= ITER;
      run_q <= 1'b1;
    end else if (stepping) begin
      rem_q <= nxt[2*N-1:N];
      quo_q <= nxt[N-1:0];
      cnt_q <= cnt_q - 1'b1;
    end else if (fin) begin
      run_q <= 1'b0;
    end
  end

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stepping && !load |=> cnt_q == $past(cnt_q) - 1'b1);

  // R7
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && run_q));
endmodule

// File: rtl/wide_divider_fix.sv
module wide_divider_fix #(
  parameter int N = 16
) (
  input  logic         sgn,
  input  logic         neg_q,
  input  logic         neg_r,
  input  logic [N-1:0] q_mag,
  input  logic [N-1:0] r_mag,
  output logic [N-1:0] q_out,
  output logic [N-1:0] r_out,
  output logic         range_ovf
);
  localparam logic [N-1:0] HALF = {1'b1, {(N-1){1'b0}}};

  function automatic logic [N-1:0] apply_sign(input logic neg, input logic [N-1:0] v);
    return neg ? (~v + 1'b1) : v;
  endfunction

  // negative quotient may reach -2^(N-1); positive must stay below 2^(N-1)
  function automatic logic out_of_range(input logic s, input logic nq, input logic [N-1:0] m);
    if (!s) return 1'b0;
    return nq ? (m > HALF) : (m >= HALF);
  endfunction

  always_comb begin
    q_out     = apply_sign(neg_q, q_mag);
    r_out     = apply_sign(neg_r, r_mag);
    range_ovf = out_of_range(sgn, neg_q, q_mag);
  end
endmodule

// File: rtl/wide_divider.sv
module wide_divider #(
  parameter int N         = 16,
  parameter bit FAST_PATH = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         sgn_mode,
  input  logic [N-1:0] dvd_hi,
  input  logic [N-1:0] dvd_lo,
  input  logic [N-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         res_ok,
  output logic         div_err,
  output logic [N-1:0] quot,
  output logic [N-1:0] rem
);
  import wide_divider_pkg::*;

  logic [N-1:0] p_hi, p_lo, p_d;
  logic         p_nq, p_nr, p_zero, p_povf, p_hzero;

  wide_divider_prep #(.N(N)) u_prep (
    .sgn(sgn_mode), .hi(dvd_hi), .lo(dvd_lo), .dvs(divisor),
    .mag_hi(p_hi), .mag_lo(p_lo), .mag_d(p_d),
    .neg_q(p_nq), .neg_r(p_nr), .zero_d(p_zero),
    .pre_ovf(p_povf), .hi_zero(p_hzero)
  );

  logic         accept;
  logic         early_err;
  logic         fast_take;
  logic [N-1:0] fast_q, fast_r;

  assign accept    = start && !busy;
  assign early_err = p_zero || p_povf;

  generate
    if (FAST_PATH) begin : g_fast
      assign fast_q    = (p_d == '0) ? '0 : p_lo / p_d;
      assign fast_r    = (p_d == '0) ? '0 : p_lo % p_d;
      assign fast_take = accept && !early_err && p_hzero;
    end else begin : g_loop_only
      assign fast_q    = '0;
      assign fast_r    = '0;
      assign fast_take = 1'b0;
    end
  endgenerate

  logic         core_load, core_run, core_fin;
  logic [N-1:0] c_q, c_r;

  assign core_load = accept && !early_err && !fast_take;

  wide_divider_core #(.N(N)) u_core (
    .clk(clk), .rst_n(rst_n), .load(core_load),
    .in_hi(p_hi), .in_lo(p_lo), .in_d(p_d),
    .running(core_run), .fin(core_fin), .q_mag(c_q), .r_mag(c_r)
  );

  logic sg_q, nq_q, nr_q;
  logic         f_sgn, f_nq, f_nr, f_ovf;
  logic [N-1:0] f_qm, f_rm, f_q, f_r;

  always_comb begin
    if (fast_take) begin
      f_sgn = sgn_mode; f_nq = p_nq; f_nr = p_nr; f_qm = fast_q; f_rm = fast_r;
    end else begin
      f_sgn = sg_q; f_nq = nq_q; f_nr = nr_q; f_qm = c_q; f_rm = c_r;
    end
  end

  wide_divider_fix #(.N(N)) u_fix (
    .sgn(f_sgn), .neg_q(f_nq), .neg_r(f_nr), .q_mag(f_qm), .r_mag(f_rm),
    .q_out(f_q), .r_out(f_r), .range_ovf(f_ovf)
  );

  div_outcome_e outcome;

  always_comb begin
    outcome = OUT_NONE;
    if (accept && early_err)           outcome = OUT_ERR;
    else if (fast_take || core_fin)    outcome = f_ovf ? OUT_ERR : OUT_OK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      res_ok  <= 1'b0;
      div_err <= 1'b0;
      quot    <= '0;
      rem     <= '0;
      sg_q    <= 1'b0;
      nq_q    <= 1'b0;
      nr_q    <= 1'b0;
    end else begin
      done    <= (outcome != OUT_NONE);
      res_ok  <= (outcome == OUT_OK);
      div_err <= (outcome == OUT_ERR);
      if (outcome == OUT_OK) begin
        quot <= f_q;
        rem  <= f_r;
      end
      if (core_load) begin
        sg_q <= sgn_mode;
        nq_q <= p_nq;
        nr_q <= p_nr;
      end
    end
  end

  assign busy = core_run;

  // R8
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (res_ok ^ div_err));

  // R8
  no_stray_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_ok || div_err) |-> done);

  // R7
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R1
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && divisor == '0 |=> div_err && !busy && $stable(quot) && $stable(rem));

  // R1
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |-> $stable(quot) && $stable(rem));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && !sgn_mode && divisor != '0 && dvd_hi >= divisor |=> div_err && !busy);
endmodule

// File: tb/wide_divider_test.sv
module wide_divider_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    bit          err;
    logic [63:0] q;
    logic [63:0] r;
    int          t0;
    int          lat;
    string       tag;
  } item_t;

  item_t sb16[$];
  item_t sb8[$];
  logic [63:0] last_q16 = '0, last_r16 = '0, last_q8 = '0, last_r8 = '0;

  // N=16 instance
  logic        s16 = 0, m16 = 0;
  logic [15:0] h16 = 0, l16 = 0, d16 = 0;
  logic        b16, dn16, ok16, er16;
  logic [15:0] q16, r16;

  wide_divider #(.N(16), .FAST_PATH(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .start(s16), .sgn_mode(m16),
    .dvd_hi(h16), .dvd_lo(l16), .divisor(d16),
    .busy(b16), .done(dn16), .res_ok(ok16), .div_err(er16), .quot(q16), .rem(r16)
  );

  // N=8 instance
  logic       s8 = 0, m8 = 0;
  logic [7:0] h8 = 0, l8 = 0, d8 = 0;
  logic       b8, dn8, ok8, er8;
  logic [7:0] q8, r8;

  wide_divider #(.N(8), .FAST_PATH(1'b1)) uut_n8 (
    .clk(clk), .rst_n(rst_n), .start(s8), .sgn_mode(m8),
    .dvd_hi(h8), .dvd_lo(l8), .divisor(d8),
    .busy(b8), .done(dn8), .res_ok(ok8), .div_err(er8), .quot(q8), .rem(r8)
  );

  task automatic check(bit cond, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model from language operators
  task automatic ref_div(input int n, input bit sg, input logic [63:0] dvd, input logic [63:0] dv,
                         output bit err, output logic [63:0] q, output logic [63:0] r,
                         output bit quick);
    logic [63:0] mn, m2n, a, b, hi;
    longint sa, sb, qs, rs;
    mn  = (64'd1 << n) - 1;
    m2n = (64'd1 << (2 * n)) - 1;
    q = '0; r = '0;
    if (!sg) begin
      a = dvd & m2n; b = dv & mn;
      if (b == 0) begin err = 1; quick = 1; return; end
      q = a / b; r = a % b;
      err = (q > mn);
      hi = a >> n;
      quick = (hi >= b) || (hi == 0);
    end else begin
      sa = $signed(dvd << (64 - 2 * n)) >>> (64 - 2 * n);
      sb = $signed(dv << (64 - n)) >>> (64 - n);
      if (sb == 0) begin err = 1; quick = 1; return; end
      qs = sa / sb; rs = sa % sb;
      err = (qs > (longint'(1) <<< (n - 1)) - 1) || (qs < -(longint'(1) <<< (n - 1)));
      q = qs; r = rs;
      hi = (sa < 0 ? -sa : sa) >> n;
      quick = (hi >= (sb < 0 ? -sb : sb)) || (hi == 0);
    end
    q = q & mn; r = r & mn;
  endtask

  task automatic issue16(bit sg, logic [31:0] dvd, logic [15:0] dv, string tag);
    item_t it; bit e, qk; logic [63:0] q, r;
    @(negedge clk);
    while (b16) @(negedge clk);
    ref_div(16, sg, {32'd0, dvd}, {48'd0, dv}, e, q, r, qk);
    if (e) begin q = last_q16; r = last_r16; end
    else begin last_q16 = q; last_r16 = r; end
    it.err = e; it.q = q; it.r = r; it.t0 = cyc + 1; it.lat = qk ? 0 : 17; it.tag = tag;
    sb16.push_back(it);
    m16 = sg; h16 = dvd[31:16]; l16 = dvd[15:0]; d16 = dv; s16 = 1;
    @(negedge clk);
    s16 = 0;
  endtask

  task automatic issue8(bit sg, logic [15:0] dvd, logic [7:0] dv, string tag);
    item_t it; bit e, qk; logic [63:0] q, r;
    @(negedge clk);
    while (b8) @(negedge clk);
    ref_div(8, sg, {48'd0, dvd}, {56'd0, dv}, e, q, r, qk);
    if (e) begin q = last_q8; r = last_r8; end
    else begin last_q8 = q; last_r8 = r; end
    it.err = e; it.q = q; it.r = r; it.t0 = cyc + 1; it.lat = qk ? 0 : 9; it.tag = tag;
    sb8.push_back(it);
    m8 = sg; h8 = dvd[15:8]; l8 = dvd[7:0]; d8 = dv; s8 = 1;
    @(negedge clk);
    s8 = 0;
  endtask

  // monitors
  always @(negedge clk) begin
    if (rst_n && dn16) begin
      if (sb16.size() == 0) check(0, "R7 uut unexpected done", 1, 0);
      else begin
        item_t it;
        it = sb16.pop_front();
        check(er16 == it.err && ok16 == !it.err, {it.tag, " R8 uut outcome"}, {62'd0, ok16, er16}, {62'd0, !it.err, it.err});
        check(q16 == it.q[15:0] && r16 == it.r[15:0], {it.tag, " uut quot/rem"}, {q16, r16}, {it.q[15:0], it.r[15:0]});
        check(cyc - it.t0 == it.lat, {it.tag, " uut latency"}, cyc - it.t0, it.lat);
      end
    end
    if (rst_n && dn8) begin
      if (sb8.size() == 0) check(0, "R7 uut_n8 unexpected done", 1, 0);
      else begin
        item_t it;
        it = sb8.pop_front();
        check(er8 == it.err && ok8 == !it.err, {it.tag, " R8 uut_n8 outcome"}, {62'd0, ok8, er8}, {62'd0, !it.err, it.err});
        check(q8 == it.q[7:0] && r8 == it.r[7:0], {it.tag, " uut_n8 quot/rem"}, {q8, r8}, {it.q[7:0], it.r[7:0]});
        check(cyc - it.t0 == it.lat, {it.tag, " uut_n8 latency"}, cyc - it.t0, it.lat);
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    check({b16, dn16, ok16, er16, q16, r16} == '0, "R9 uut reset", {b16, dn16, ok16, er16, q16, r16}, 0);
    check({b8, dn8, ok8, er8, q8, r8} == '0, "R9 uut_n8 reset", {b8, dn8, ok8, er8, q8, r8}, 0);

    // R4 unsigned loop
    issue16(0, 32'h0012_3456, 16'h0100, "R4");
    issue16(0, 32'hFFFE_FFFF, 16'hFFFF, "R4 max");
    issue16(0, 32'h8000_0001, 16'h8001, "R4 topbit");
    // R1 zero divisor keeps registers
    issue16(0, 32'h0000_1234, 16'h0000, "R1");
    issue16(1, 32'hFFFF_FFFF, 16'h0000, "R1 signed");
    // R2 certain overflow
    issue16(0, 32'h0100_0000, 16'h0100, "R2");
    issue16(0, 32'hFFFF_0000, 16'h0001, "R2 big");
    issue16(1, 32'h8000_0000, 16'h8000, "R2 most negative");
    // R3 fast path
    issue16(0, 32'h0000_ABCD, 16'h0007, "R3");
    issue16(1, 32'hFFFF_8000, 16'h0001, "R3 R6 min quotient ok");
    issue16(1, 32'hFFFF_8000, 16'hFFFF, "R3 R6 positive overflow");
    // R5 signed loop
    issue16(1, 32'hFFF0_0001, 16'h0123, "R5 neg dividend");
    issue16(1, 32'h0012_3457, 16'hFF00, "R5 neg divisor");
    issue16(1, 32'hFFED_CBA9, 16'hFEDC, "R5 both neg");
    // R6 boundaries after iteration
    issue16(1, 32'hFF80_0000, 16'h0100, "R6 -2^15 valid");
    issue16(1, 32'hFF80_0000, 16'hFF00, "R6 +2^15 overflow");
    issue16(1, 32'h007F_FF00, 16'h0100, "R6 max positive");
    issue16(1, 32'hFF7F_FF00, 16'h0100, "R6 below min");

    // R7 ignored starts while busy
    issue16(0, 32'h0055_AAAA, 16'h1234, "R7 long op");
    for (int k = 0; k < 3; k++) begin
      check(b16 == 1'b1, "R7 busy during loop", b16, 1);
      m16 = 0; h16 = 16'h0000; l16 = 16'h0009; d16 = 16'h0003; s16 = 1;
      @(negedge clk);
      s16 = 0;
    end
    issue8(0, 16'h1234, 8'h56, "R7 n8 long op");
    check(b8 == 1'b1, "R7 n8 busy", b8, 1);
    s8 = 1; d8 = 0;
    @(negedge clk);
    s8 = 0;

    // N=8 directed
    issue8(0, 16'hFE01, 8'hFF, "R4 n8");
    issue8(0, 16'h0000, 8'h00, "R1 n8");
    issue8(0, 16'h0500, 8'h05, "R2 n8");
    issue8(1, 16'h8000, 8'h80, "R2 n8 most negative");
    issue8(1, 16'hC000, 8'h80, "R6 n8 +128 overflow");
    issue8(1, 16'h4000, 8'h80, "R6 n8 -128 valid");
    issue8(1, 16'hFF80, 8'hFF, "R3 n8 overflow");
    issue8(1, 16'hE001, 8'h7F, "R5 n8");

    // mixed sweep
    for (int k = 0; k < 60; k++) begin
      logic [15:0] dv; logic [15:0] hi; logic [7:0] dv8;
      dv  = 16'($urandom);
      dv8 = 8'($urandom);
      hi  = (dv == 0) ? 16'd0 : 16'($urandom) % dv;
      issue16(k[0], {hi, 16'($urandom)}, dv, k[0] ? "R5 sweep" : "R4 sweep");
      issue8(k[1], 16'($urandom), dv8, k[1] ? "R5 n8 sweep" : "R4 n8 sweep");
    end

    while (b16 || b8 || sb16.size() != 0 || sb8.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule